// File: doc/BRIEF.md
# BCD Real-Time Clock and Calendar Register File

This block holds the time of day and the calendar date as eight byte-wide registers, every time and date field kept in packed BCD. The tens digit sits in the upper nibble and the units digit in the lower nibble. A one-cycle pulse on the second-tick input advances the count by one second. The carry then passes in turn to minutes, hours, date, month and year. The day-of-week register steps together with the date. The hours register can count in 24-hour or 12-hour format, and in 12-hour format it keeps a PM flag.

A host-side interface, outside this block, loads any register through the write port and reads any register through the registered read port. A halt bit in the seconds register stops all counting, so software can set the time without a tick landing partway through the update.

Top module: `rtc_bcd_regfile`

## Requirements
- R1: Seconds and minutes count in packed BCD from 00 to 59. Units 9 carries into the tens nibble, and 59 wraps to 00 and carries into the next field.
- R2: When the halt bit is 0, a tick advances seconds by exactly one BCD step. For example, 0x10 becomes 0x11 and 0x09 becomes 0x10.
- R3: When bit 7 of seconds (the halt bit) is 1, ticks change no register. Writes still take effect while halted.
- R4: When bit 7 of hours is 0, the block is in 24-hour format and bits 5:4 hold the tens of hours. A step from 0x23 gives 0x00 and advances the date.
- R5: When bit 7 of hours is 1, the block is in 12-hour format. Bit 5 is the PM flag (1 = PM) and bit 4 holds the tens of hours. A step from 11 gives 12 and inverts the PM flag. A step from 12 gives 01. The date advances only on the step from 11 PM to 12 AM.
- R6: When the date steps past the last day of its month, it wraps to 01 and advances the month. February has 29 days when the BCD year is a multiple of 4 and 28 days otherwise. April, June, September and November have 30 days, and all other months have 31.
- R7: A step from month 12 gives 01 and advances the year. A step from year 99 gives 00.
- R8: Day of week counts 1 to 7 and wraps from 7 to 1. It steps exactly when the date steps.
- R9: The register addresses are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day, 6 year and 7 control. rd_data shows, one clock after a rising edge, the content the register at rd_addr held before that edge.
- R10: A write in the same cycle as a tick loads the written value into the addressed register, and that register drops the tick's increment. All other registers still apply the tick, including the carries computed from the old register contents.
- R11: Bits that have no use are stored and read as zero. These are bit 7 of minutes, bit 6 of hours, bits 7:6 of date, bits 7:5 of month, bits 7:3 of day, and bits 6:0 of control. Control bit 7 is stored as written.
- R12: Synchronous reset sets seconds 0x00, minutes 0x00, hours 0x00, date 0x01, month 0x01, day 0x01, year 0x00 and control 0x00, and sets rd_data to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second increment pulse |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register address to write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Register address to read |
| rd_data | output | 8 | Registered read data |

## Verification
The assertions check four things on every cycle:
- the freeze while halted;
- the seconds units step;
- write priority on the year register;
- the one-cycle read path and the zero bits.

The carry chains across month lengths, leap years and the two hour formats can only be shown by the bench's scenarios. These include the 12-hour PM boundary, the end-of-century rollover and the tick-and-write collision, which the bench checks against a model kept in binary arithmetic.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned N_REGS = 8;
  localparam int unsigned ADDR_W = $clog2(N_REGS);
  localparam int unsigned BYTE_W = 8;

  typedef logic [BYTE_W-1:0] rtc_byte_t;
  typedef rtc_byte_t [N_REGS-1:0] bank_t;

  localparam int unsigned IX_SEC   = 0;
  localparam int unsigned IX_MIN   = 1;
  localparam int unsigned IX_HOUR  = 2;
  localparam int unsigned IX_DATE  = 3;
  localparam int unsigned IX_MONTH = 4;
  localparam int unsigned IX_DAY   = 5;
  localparam int unsigned IX_YEAR  = 6;
  localparam int unsigned IX_CTRL  = 7;

  // One packed-BCD step with nibble carry
  function automatic rtc_byte_t bcd_inc(input rtc_byte_t b);
    if (b[3:0] == 4'h9) return {b[7:4] + 4'h1, 4'h0};
    return {b[7:4], b[3:0] + 4'h1};
  endfunction

  // A BCD year is a multiple of four when an even tens digit pairs with 0/4/8
  // or an odd tens digit pairs with 2/6
  function automatic logic bcd_leap(input rtc_byte_t y);
    if (!y[4]) return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
    return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
  endfunction

  function automatic rtc_byte_t last_day(input rtc_byte_t mon, input rtc_byte_t yr);
    case (mon)
      8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic rtc_byte_t keep_mask(input int unsigned ix);
    case (ix)
      IX_MIN:   return 8'h7F;
      IX_HOUR:  return 8'hBF;
      IX_DATE:  return 8'h3F;
      IX_MONTH: return 8'h1F;
      IX_DAY:   return 8'h07;
      IX_CTRL:  return 8'h80;
      default:  return 8'hFF;
    endcase
  endfunction

  function automatic rtc_byte_t init_val(input int unsigned ix);
    case (ix)
      IX_DATE, IX_MONTH, IX_DAY: return 8'h01;
      default:                   return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic  tick,
  input  bank_t cur,
  output bank_t nxt
);
  logic      run, min_step, hour_step, date_step, month_step, year_step;
  logic      date_wrap;
  rtc_byte_t sec7, h12, h24, t;

  always_comb begin
    nxt        = cur;
    run        = tick & ~cur[IX_SEC][7];
    sec7       = {1'b0, cur[IX_SEC][6:0]};
    h12        = {3'b000, cur[IX_HOUR][4:0]};
    h24        = {2'b00, cur[IX_HOUR][5:0]};
    t          = '0;
    min_step   = 1'b0;
    hour_step  = 1'b0;
    date_step  = 1'b0;
    date_wrap  = 1'b0;
    month_step = 1'b0;
    year_step  = 1'b0;

    if (run) begin
      min_step = (sec7 == 8'h59);
      t        = min_step ? 8'h00 : bcd_inc(sec7);
      nxt[IX_SEC] = {cur[IX_SEC][7], t[6:0]};
    end

    if (min_step) begin
      hour_step   = (cur[IX_MIN] == 8'h59);
      nxt[IX_MIN] = hour_step ? 8'h00 : bcd_inc(cur[IX_MIN]);
    end

    if (hour_step) begin
      if (cur[IX_HOUR][7]) begin
        if (h12 == 8'h11) begin
          nxt[IX_HOUR] = {1'b1, 1'b0, ~cur[IX_HOUR][5], 5'h12};
          date_step    = cur[IX_HOUR][5];
        end else if (h12 == 8'h12) begin
          nxt[IX_HOUR] = {1'b1, 1'b0, cur[IX_HOUR][5], 5'h01};
        end else begin
          t            = bcd_inc(h12);
          nxt[IX_HOUR] = {1'b1, 1'b0, cur[IX_HOUR][5], t[4:0]};
        end
      end else begin
        if (h24 == 8'h23) begin
          nxt[IX_HOUR] = 8'h00;
          date_step    = 1'b1;
        end else begin
          t            = bcd_inc(h24);
          nxt[IX_HOUR] = {2'b00, t[5:0]};
        end
      end
    end

    if (date_step) begin
      date_wrap    = (cur[IX_DATE] == last_day(cur[IX_MONTH], cur[IX_YEAR]));
      nxt[IX_DATE] = date_wrap ? 8'h01 : bcd_inc(cur[IX_DATE]);
      nxt[IX_DAY]  = (cur[IX_DAY][2:0] == 3'd7) ? 8'h01 : {5'd0, cur[IX_DAY][2:0] + 3'd1};
      month_step   = date_wrap;
    end

    if (month_step) begin
      year_step     = (cur[IX_MONTH] == 8'h12);
      nxt[IX_MONTH] = year_step ? 8'h01 : bcd_inc(cur[IX_MONTH]);
    end

    if (year_step) begin
      nxt[IX_YEAR] = (cur[IX_YEAR] == 8'h99) ? 8'h00 : bcd_inc(cur[IX_YEAR]);
    end
  end
endmodule

// File: rtl/rtc_reg_bank.sv
module rtc_reg_bank
  import rtc_pkg::*;
#(
  parameter int unsigned NR = N_REGS,
  localparam int unsigned AW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  rtc_byte_t     wr_data,
  input  bank_t         nxt,
  output bank_t         bank_q
);
  for (genvar i = 0; i < NR; i++) begin : g_reg
    localparam rtc_byte_t MASK = keep_mask(i);
    localparam rtc_byte_t RVAL = init_val(i);
    always_ff @(posedge clk) begin
      if (rst)                                 bank_q[i] <= RVAL;
      else if (wr_en && (wr_addr == AW'(i)))   bank_q[i] <= wr_data & MASK;
      else                                     bank_q[i] <= nxt[i];
    end
  end
endmodule

// File: rtl/rtc_bcd_regfile.sv
module rtc_bcd_regfile
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  bank_t bank_q, bank_nxt;

  rtc_time_chain u_chain (
    .tick (tick),
    .cur  (bank_q),
    .nxt  (bank_nxt)
  );

  rtc_reg_bank #(.NR(N_REGS)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .nxt     (bank_nxt),
    .bank_q  (bank_q)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= bank_q[rd_addr];
  end
endmodule

// File: rtl/rtc_bcd_regfile_chk.sv
module rtc_bcd_regfile_chk
  import rtc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BYTE_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [BYTE_W-1:0] rd_data,
  input bank_t             bank
);
  p_halt_freeze_r3: assert property (@(posedge clk) disable iff (rst)
    $past(bank[IX_SEC][7] && !wr_en && !rst) |-> (bank == $past(bank)));

  p_sec_step_r2: assert property (@(posedge clk) disable iff (rst)
    $past(tick && !wr_en && !rst && !bank[IX_SEC][7] && (bank[IX_SEC][3:0] != 4'h9))
    |-> (bank[IX_SEC][3:0] == $past(bank[IX_SEC][3:0]) + 4'h1));

  p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && (wr_addr == ADDR_W'(IX_YEAR)) && !rst) |-> (bank[IX_YEAR] == $past(wr_data)));

  p_read_path_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rd_data == $past(bank[rd_addr])));

  p_zero_bits_r11: assert property (@(posedge clk) disable iff (rst)
    (bank[IX_MIN][7] == 1'b0) && (bank[IX_HOUR][6] == 1'b0) && (bank[IX_DATE][7:6] == 2'b00)
    && (bank[IX_MONTH][7:5] == 3'b000) && (bank[IX_DAY][7:3] == 5'd0) && (bank[IX_CTRL][6:0] == 7'd0));
endmodule

bind rtc_bcd_regfile rtc_bcd_regfile_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .bank    (bank_q)
);

// File: tb/rtc_bcd_regfile_tb.sv
module rtc_bcd_regfile_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_bcd_regfile dut_i (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int mdays(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] fmask(input int a);
    logic [7:0] k [8] = '{8'hFF, 8'h7F, 8'hBF, 8'h3F, 8'h1F, 8'h07, 8'hFF, 8'h80};
    return k[a];
  endfunction

  // Reference model in binary arithmetic
  task automatic mstep(input bit t, input bit we, input logic [2:0] wa, input logic [7:0] wd);
    logic [7:0] n [8];
    int s, mi, h, d, mo, y, dw;
    bit cm, ch, cd, cmo, cy, pm;
    n = m;
    cm = 0; ch = 0; cd = 0; cmo = 0; cy = 0;
    if (t && !m[0][7]) begin
      s = b2i({1'b0, m[0][6:0]}) + 1;
      if (s == 60) begin s = 0; cm = 1; end
      n[0] = {m[0][7], i2b(s)[6:0]};
    end
    if (cm) begin
      mi = b2i(m[1]) + 1;
      if (mi == 60) begin mi = 0; ch = 1; end
      n[1] = i2b(mi);
    end
    if (ch) begin
      if (m[2][7]) begin
        h = b2i({3'b0, m[2][4:0]}); pm = m[2][5];
        if (h == 11) begin h = 12; cd = pm; pm = !pm; end
        else if (h == 12) h = 1;
        else h = h + 1;
        n[2] = {1'b1, 1'b0, pm, i2b(h)[4:0]};
      end else begin
        h = b2i({2'b0, m[2][5:0]}) + 1;
        if (h == 24) begin h = 0; cd = 1; end
        n[2] = i2b(h);
      end
    end
    if (cd) begin
      d = b2i(m[3]); mo = b2i(m[4]); y = b2i(m[6]);
      if (d == mdays(mo, y)) begin d = 1; cmo = 1; end else d = d + 1;
      n[3] = i2b(d);
      dw = int'(m[5][2:0]);
      n[5] = (dw == 7) ? 8'h01 : 8'(dw + 1);
    end
    if (cmo) begin
      mo = b2i(m[4]) + 1;
      if (mo == 13) begin mo = 1; cy = 1; end
      n[4] = i2b(mo);
    end
    if (cy) begin
      y = b2i(m[6]) + 1;
      n[6] = i2b(y % 100);
    end
    if (we) n[wa] = wd & fmask(int'(wa));
    m = n;
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input bit t, input bit we, input logic [2:0] wa,
                      input logic [7:0] wd, input logic [2:0] ra);
    logic [7:0] exp;
    @(negedge clk);
    tick = t; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    exp = m[ra];
    mstep(t, we, wa, wd);
    @(posedge clk);
    #1;
    chk("R9 read path", rd_data, exp);
    @(negedge clk);
    tick = 0; wr_en = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step(0, 1, a, d, 0);
  endtask

  task automatic tk();
    step(1, 0, 0, 0, 0);
  endtask

  task automatic rdchk(input logic [2:0] a, input logic [7:0] e, input string req);
    step(0, 0, 0, 0, a);
    @(posedge clk); #1;
    chk(req, rd_data, e);
  endtask

  task automatic set_time(input logic [7:0] hr, input logic [7:0] dt, input logic [7:0] mo,
                          input logic [7:0] dw, input logic [7:0] yr);
    wr(6, yr); wr(4, mo); wr(3, dt); wr(5, dw); wr(2, hr); wr(1, 8'h59); wr(0, 8'h59);
  endtask

  function automatic logic [7:0] rand_val(input int a);
    logic [7:0] v;
    case (a)
      0: v = ($urandom % 2) ? 8'h59 : i2b($urandom % 60);
      1: v = ($urandom % 2) ? 8'h59 : i2b($urandom % 60);
      2: if ($urandom % 2) v = {1'b1, 1'b0, 1'($urandom), (($urandom % 2) ? 5'h11 : i2b(1 + $urandom % 12)[4:0])};
         else v = ($urandom % 2) ? 8'h23 : i2b($urandom % 24);
      3: v = i2b(1 + $urandom % 28);
      4: v = i2b(1 + $urandom % 12);
      5: v = 8'(1 + $urandom % 7);
      6: v = i2b($urandom % 100);
      default: v = 8'($urandom);
    endcase
    if (a == 0 && ($urandom % 8) == 0) v[7] = 1'b1;
    if (a != 0 && a != 6 && ($urandom % 4) == 0) v = v | ~fmask(a);
    return v;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    m = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00};
    @(posedge clk); #1;
    chk("R12 rd_data after reset", rd_data, 8'h00);
    rdchk(0, 8'h00, "R12 seconds"); rdchk(2, 8'h00, "R12 hours");
    rdchk(3, 8'h01, "R12 date");    rdchk(4, 8'h01, "R12 month");
    rdchk(5, 8'h01, "R12 day");     rdchk(7, 8'h00, "R12 control");

    // full rollover at end of year 99, 24-hour format
    set_time(8'h23, 8'h31, 8'h12, 8'h07, 8'h99);
    tk();
    rdchk(0, 8'h00, "R1 seconds wrap"); rdchk(1, 8'h00, "R1 minutes wrap");
    rdchk(2, 8'h00, "R4 hour 23 wrap"); rdchk(3, 8'h01, "R6 date 31 wrap");
    rdchk(4, 8'h01, "R7 month wrap");   rdchk(6, 8'h00, "R7 year 99 wrap");
    rdchk(5, 8'h01, "R8 day 7 wrap");

    // 12-hour format
    set_time(8'hB1, 8'h05, 8'h03, 8'h03, 8'h23);
    tk();
    rdchk(2, 8'h92, "R5 11PM to 12AM"); rdchk(3, 8'h06, "R5 date after 11PM");
    rdchk(5, 8'h04, "R8 day steps with date");
    wr(2, 8'h91); wr(1, 8'h59); wr(0, 8'h59); tk();
    rdchk(2, 8'hB2, "R5 11AM to 12PM"); rdchk(3, 8'h06, "R5 no date step at noon");
    wr(2, 8'hB2); wr(1, 8'h59); wr(0, 8'h59); tk();
    rdchk(2, 8'hA1, "R5 12 to 01");

    // month lengths and leap years
    set_time(8'h23, 8'h28, 8'h02, 8'h01, 8'h24);
    tk();
    rdchk(3, 8'h29, "R6 leap Feb 29"); rdchk(4, 8'h02, "R6 leap month held");
    wr(2, 8'h23); wr(1, 8'h59); wr(0, 8'h59); tk();
    rdchk(3, 8'h01, "R6 leap Feb end"); rdchk(4, 8'h03, "R6 leap to March");
    set_time(8'h23, 8'h28, 8'h02, 8'h01, 8'h23);
    tk();
    rdchk(3, 8'h01, "R6 common Feb end"); rdchk(4, 8'h03, "R6 common to March");
    set_time(8'h23, 8'h30, 8'h04, 8'h01, 8'h23);
    tk();
    rdchk(3, 8'h01, "R6 April end"); rdchk(4, 8'h05, "R6 to May");

    // halt
    wr(1, 8'h20); wr(0, 8'h90);
    for (int i = 0; i < 5; i++) tk();
    rdchk(0, 8'h90, "R3 halted seconds"); rdchk(1, 8'h20, "R3 halted minutes");
    wr(1, 8'h33);
    rdchk(1, 8'h33, "R3 write while halted");
    wr(0, 8'h10); tk();
    rdchk(0, 8'h11, "R2 step after release");
    wr(0, 8'h09); tk();
    rdchk(0, 8'h10, "R2 nibble carry");

    // write and tick in one cycle
    wr(1, 8'h10); wr(0, 8'h59);
    step(1, 1, 0, 8'h30, 0);
    rdchk(0, 8'h30, "R10 written value kept"); rdchk(1, 8'h11, "R10 carry still applied");

    // unused bits
    wr(1, 8'hD9); rdchk(1, 8'h59, "R11 minutes bit7");
    wr(5, 8'hFF); rdchk(5, 8'h07, "R11 day bits");
    wr(7, 8'hFF); rdchk(7, 8'h80, "R11 control bits");
    wr(3, 8'hC5); rdchk(3, 8'h05, "R11 date bits");
    wr(4, 8'hE9); rdchk(4, 8'h09, "R11 month bits");
    wr(2, 8'h52); rdchk(2, 8'h12, "R11 hours bit6");

    // random mix against the model
    for (int i = 0; i < 3000; i++) begin
      bit we;
      logic [2:0] a;
      we = (($urandom % 6) == 0);
      a  = 3'($urandom);
      step(1'($urandom), we, a, rand_val(int'(a)), 3'($urandom));
    end
    finish_run();
  end
endmodule